// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Trigger-Level Receive Queue

This block is the receive half of an asynchronous serial port. It watches the serial line for the falling edge that opens a frame. It then sends a one-cycle restart pulse to the baud counter so that the counter's bit ticks fall in the middle of each bit. Each later tick samples the line. The first tick confirms the start bit. The next ticks shift in 5 to 8 data bits, least significant bit first. An optional parity bit follows, then the stop bit.

The completed word goes into a small receive queue. The queue can be run in single-word mode or as a FIFO. The data-ready flag follows the word count: it rises on any word in single-word mode, and on reaching a programmed trigger level in FIFO mode. Parity, framing and overrun errors are held in sticky flags until a clear strobe.

Top module: `uart_rx_fifo_trig`

## Requirements
- R1: In idle, a high-to-low change of `rxd` seen at a clock edge raises `restart` for exactly one cycle. Falling edges inside a frame raise no restart, so each frame gives exactly one pulse.
- R2: At the first `bit_tick` after the restart, a high `rxd` marks a false start. The receiver returns to idle, stores nothing and sets no flag.
- R3: The data width is 5 + `cfg_len` (code 0 = 5 bits … 3 = 8 bits). Bits arrive LSB first. The stored word is right-aligned in `rd_data`, with the unused upper bits zero.
- R4: With `cfg_par_en` = 1 a parity bit follows the data. Even parity (`cfg_par_odd` = 0) or odd parity (`cfg_par_odd` = 1) is checked over data plus parity bit. A mismatch sets `err_par`.
- R5: A low stop-bit sample sets `err_frm`. The word is still stored.
- R6: With `cfg_fifo_en` = 0 the queue holds one word. `rdrf` is high while that word is held and falls after `rd_en` reads it.
- R7: With `cfg_fifo_en` = 1, `rdrf` is high exactly when the word count is at least the trigger level. The trigger level is `cfg_trig`, with 0 treated as 1 and values above DEPTH treated as DEPTH. Reads that drop the count below the trigger level clear `rdrf`.
- R8: A word that completes while the queue is full sets `err_ovr` and is dropped. The queue is full at 1 word in single-word mode and at DEPTH words in FIFO mode. The words already held are kept intact.
- R9: Error flags stay set until `err_clr`. If an error is set in the same cycle as `err_clr`, the error flag is set.
- R10: Words leave the queue in arrival order. `rd_data` shows the oldest word, and `rd_en` with an empty queue does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial input, already synchronised, idles high |
| bit_tick | input | 1 | Mid-bit sample strobe from the baud counter |
| cfg_len | input | 2 | Data width code, bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_fifo_en | input | 1 | 1 = FIFO mode, 0 = single-word mode |
| cfg_trig | input | CW | FIFO trigger level |
| rd_en | input | 1 | Pop the oldest word |
| err_clr | input | 1 | Clear the error flags |
| restart | output | 1 | Resync pulse to the baud counter |
| rdrf | output | 1 | Receive data ready |
| rd_data | output | 8 | Oldest word, right-aligned |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |

## Verification
The bench sweeps every data width under every parity mode with patterns that place ones at both word edges. A design that aligned the word wrongly, or leaked stale shift bits into the upper bits, would return the wrong value. A design with inverted parity would flag good frames.

It also sweeps every trigger level, including 0, in FIFO mode. It checks `rdrf` after each write and after each read, so an off-by-one in the trigger compare shows up at the level boundary.

Overrun is driven in both modes. A design that overwrote the oldest word instead of dropping the new one would return the wrong data.

A false start, a low stop bit, and a clear strobe that coincides with a new error catch a receiver that stores glitches, drops framing-errored words, or lets the clear win.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned MAX_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // number of data bits for a width code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'(MIN_BITS) + {2'b00, code};
  endfunction

  // bits enter at the top of the shifter, so a short word sits high
  function automatic logic [MAX_BITS-1:0] align_word(input logic [MAX_BITS-1:0] sh,
                                                     input logic [3:0] nbits);
    return sh >> (4'(MAX_BITS) - nbits);
  endfunction

  // 1 when data parity plus received bit disagree with the selected sense
  function automatic logic parity_bad(input logic acc, input logic pbit, input logic odd);
    return acc ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/uart_rx_start_det.sv
module uart_rx_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic armed,
  output logic fall,
  output logic restart
);

  logic rxd_q;

  assign fall = armed & rxd_q & ~rxd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q   <= 1'b1;
      restart <= 1'b0;
    end else begin
      rxd_q   <= rxd;
      restart <= fall;
    end
  end

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd,
  input  logic                bit_tick,
  input  logic                start_fall,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  output logic                idle,
  output logic                false_start,
  output logic                stop_tick,
  output logic                done,
  output logic [MAX_BITS-1:0] word,
  output logic                perr,
  output logic                ferr
);

  rx_state_e           state;
  logic [MAX_BITS-1:0] sh;
  logic [3:0]          cnt;
  logic [3:0]          nbits;
  logic                acc;
  logic                perr_r;

  assign nbits       = data_bits(cfg_len);
  assign idle        = (state == RX_IDLE);
  assign false_start = (state == RX_START) & bit_tick & rxd;
  assign stop_tick   = (state == RX_STOP) & bit_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      sh     <= '0;
      cnt    <= '0;
      acc    <= 1'b0;
      perr_r <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (start_fall) state <= RX_START;
        end
        RX_START: begin
          if (bit_tick) begin
            if (rxd) begin
              state <= RX_IDLE;
            end else begin
              state  <= RX_DATA;
              cnt    <= '0;
              acc    <= 1'b0;
              perr_r <= 1'b0;
              sh     <= '0;
            end
          end
        end
        RX_DATA: begin
          if (bit_tick) begin
            sh  <= {rxd, sh[MAX_BITS-1:1]};
            acc <= acc ^ rxd;
            cnt <= cnt + 4'd1;
            if (cnt == nbits - 4'd1) state <= cfg_par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (bit_tick) begin
            perr_r <= parity_bad(acc, rxd, cfg_par_odd);
            state  <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (bit_tick) begin
            done  <= 1'b1;
            word  <= align_word(sh, nbits);
            perr  <= perr_r;
            ferr  <= ~rxd;
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= nxt(wptr);
      if (rd) rptr <= nxt(rptr);
      if (wr && !rd)      count <= count + CW'(1);
      else if (rd && !wr) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/uart_rx_fifo_trig.sv
module uart_rx_fifo_trig
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd,
  input  logic                bit_tick,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_fifo_en,
  input  logic [CW-1:0]       cfg_trig,
  input  logic                rd_en,
  input  logic                err_clr,
  output logic                restart,
  output logic                rdrf,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                err_par,
  output logic                err_frm,
  output logic                err_ovr
);

  // named internal events, also used by the checker
  logic                evt_fall;
  logic                evt_idle;
  logic                evt_false_start;
  logic                evt_stop_tick;
  logic                evt_done;
  logic [MAX_BITS-1:0] done_word;
  logic                done_perr;
  logic                done_ferr;
  logic                evt_wr;
  logic                evt_ovr;
  logic                evt_rd;
  logic                q_full;
  logic [CW-1:0]       q_cnt;
  logic [CW-1:0]       cap;
  logic [CW-1:0]       trig_eff;

  uart_rx_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd     (rxd),
    .armed   (evt_idle),
    .fall    (evt_fall),
    .restart (restart)
  );

  uart_rx_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd         (rxd),
    .bit_tick    (bit_tick),
    .start_fall  (evt_fall),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .idle        (evt_idle),
    .false_start (evt_false_start),
    .stop_tick   (evt_stop_tick),
    .done        (evt_done),
    .word        (done_word),
    .perr        (done_perr),
    .ferr        (done_ferr)
  );

  uart_rx_queue #(.DEPTH(DEPTH), .DW(MAX_BITS)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (evt_wr),
    .wdata (done_word),
    .rd    (evt_rd),
    .rdata (rd_data),
    .count (q_cnt)
  );

  always_comb begin
    if (cfg_trig == '0)                  trig_eff = CW'(1);
    else if (cfg_trig > CW'(DEPTH))      trig_eff = CW'(DEPTH);
    else                                 trig_eff = cfg_trig;
  end

  assign cap     = cfg_fifo_en ? CW'(DEPTH) : CW'(1);
  assign q_full  = (q_cnt >= cap);
  assign evt_wr  = evt_done & ~q_full;
  assign evt_ovr = evt_done & q_full;
  assign evt_rd  = rd_en & (q_cnt != '0);
  assign rdrf    = cfg_fifo_en ? (q_cnt >= trig_eff) : (q_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_par <= 1'b0;
      err_frm <= 1'b0;
      err_ovr <= 1'b0;
    end else begin
      err_par <= (evt_done & done_perr) | (err_par & ~err_clr);
      err_frm <= (evt_done & done_ferr) | (err_frm & ~err_clr);
      err_ovr <= evt_ovr                | (err_ovr & ~err_clr);
    end
  end

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          evt_done,
  input logic          done_ferr,
  input logic          evt_ovr,
  input logic          evt_rd,
  input logic [CW-1:0] q_cnt,
  input logic          err_clr,
  input logic          err_par,
  input logic          err_frm,
  input logic          err_ovr
);

  p_restart_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  p_frm_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && done_ferr) |=> err_frm);

  p_ovr_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovr |=> err_ovr);

  p_ovr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ovr && !evt_rd) |=> $stable(q_cnt));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !evt_done) |=> (!err_par && !err_frm && !err_ovr));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == $past(q_cnt)) || (q_cnt == $past(q_cnt) + CW'(1)) ||
    (q_cnt + CW'(1) == $past(q_cnt)));

endmodule

bind uart_rx_fifo_trig uart_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .evt_done  (evt_done),
  .done_ferr (done_ferr),
  .evt_ovr   (evt_ovr),
  .evt_rd    (evt_rd),
  .q_cnt     (q_cnt),
  .err_clr   (err_clr),
  .err_par   (err_par),
  .err_frm   (err_frm),
  .err_ovr   (err_ovr)
);

// File: tb/tb_uart_rx_fifo_trig.sv
module tb_uart_rx_fifo_trig;

  localparam int DEPTH = 4;
  localparam int CW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          bit_tick = 1'b0;
  logic [1:0]    cfg_len = 2'd3;
  logic          cfg_par_en = 1'b0;
  logic          cfg_par_odd = 1'b0;
  logic          cfg_fifo_en = 1'b0;
  logic [CW-1:0] cfg_trig = '0;
  logic          rd_en = 1'b0;
  logic          err_clr = 1'b0;
  logic          restart;
  logic          rdrf;
  logic [7:0]    rd_data;
  logic          err_par;
  logic          err_frm;
  logic          err_ovr;

  int checks = 0;
  int failures = 0;
  int restarts = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo_trig #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_fifo_en(cfg_fifo_en), .cfg_trig(cfg_trig), .rd_en(rd_en),
    .err_clr(err_clr), .restart(restart), .rdrf(rdrf), .rd_data(rd_data),
    .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr)
  );

  always @(posedge clk) if (rst_n && restart) restarts <= restarts + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (2) @(negedge clk);
    tick();
    repeat (2) @(negedge clk);
  endtask

  // stop_val 0 gives a framing error; clr_at_stop holds err_clr across the store cycle
  task automatic send_frame(input logic [7:0] data, input logic flip_par,
                            input logic stop_val, input logic clr_at_stop);
    int n;
    logic pb;
    int r0;
    n  = 5 + int'(cfg_len);
    pb = ^(data & 8'((1 << n) - 1)) ^ cfg_par_odd ^ flip_par;
    r0 = restarts;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(data[i]);
    if (cfg_par_en) send_bit(pb);
    if (clr_at_stop) begin
      @(negedge clk) rxd = stop_val;
      repeat (2) @(negedge clk);
      err_clr = 1'b1;
      tick();
      @(negedge clk) err_clr = 1'b0;
      chk(err_frm == 1'b1, "R9 set wins over clear", err_frm, 1);
      @(negedge clk) rxd = 1'b1;
    end else begin
      send_bit(stop_val);
      @(negedge clk) rxd = 1'b1;
    end
    repeat (3) @(negedge clk);
    chk(restarts == r0 + 1, "R1 one restart per frame", restarts - r0, 1);
  endtask

  task automatic read_chk(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rd_data == exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h01; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h96;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdrf == 0 && err_par == 0 && err_frm == 0 && err_ovr == 0 && restart == 0,
        "reset state", {rdrf, err_par, err_frm, err_ovr}, 0);

    // R1: pulse timing on a single start edge
    cfg_len = 2'd3;
    rxd = 1'b0;
    @(negedge clk);
    chk(restart == 1'b1, "R1 restart after edge", restart, 1);
    @(negedge clk);
    chk(restart == 1'b0, "R1 restart one cycle", restart, 0);
    // R2: line back high before the first tick, so the start is false
    rxd = 1'b1;
    repeat (2) @(negedge clk);
    tick();
    repeat (3) @(negedge clk);
    chk(rdrf == 1'b0, "R2 false start stores nothing", rdrf, 0);
    chk({err_par, err_frm, err_ovr} == 3'b000, "R2 false start no flag",
        {err_par, err_frm, err_ovr}, 0);
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
    read_chk(8'h5A, "R2 receiver recovers after false start");

    // R3 R4 R6: sweep widths and parity modes in single-word mode
    for (int l = 0; l < 4; l++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int d = 0; d < 4; d++) begin
          logic inj;
          logic [7:0] exp;
          cfg_len     = 2'(l);
          cfg_par_en  = (pm != 0);
          cfg_par_odd = (pm == 2);
          inj = (pm != 0) && (d == 3);
          exp = pats[d] & 8'((1 << (5 + l)) - 1);
          send_frame(pats[d], inj, 1'b1, 1'b0);
          chk(rdrf == 1'b1, "R6 ready with one word", rdrf, 1);
          chk(err_par == inj, "R4 parity check", err_par, inj);
          chk(err_frm == 1'b0, "R5 good stop", err_frm, 0);
          read_chk(exp, "R3 width and alignment");
          chk(rdrf == 1'b0, "R6 ready clears on read", rdrf, 0);
          clear_errs();
        end
      end
    end
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R5: low stop bit; word still stored
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
    chk(err_frm == 1'b1, "R5 framing error", err_frm, 1);
    read_chk(8'hC3, "R5 word kept on framing error");
    clear_errs();
    chk(err_frm == 1'b0, "R9 clear strobe", err_frm, 0);
    // R9: clear in the same cycle as a new error
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    read_chk(8'h3C, "R9 data");
    clear_errs();

    // R8: overrun in single-word mode
    send_frame(8'h11, 1'b0, 1'b1, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0);
    chk(err_ovr == 1'b1, "R8 overrun single", err_ovr, 1);
    read_chk(8'h11, "R8 held word kept");
    chk(rdrf == 1'b0, "R8 dropped word absent", rdrf, 0);
    rd_en = 1'b1; @(negedge clk) rd_en = 1'b0;
    chk(rdrf == 1'b0, "R10 read of empty queue", rdrf, 0);
    clear_errs();

    // R7 R10: trigger sweep in FIFO mode, trigger 0 acts as 1
    cfg_fifo_en = 1'b1;
    for (int t = 0; t <= DEPTH; t++) begin
      int te;
      cfg_trig = CW'(t);
      te = (t == 0) ? 1 : t;
      for (int k = 1; k <= DEPTH; k++) begin
        send_frame(8'(k * 37 + t), 1'b0, 1'b1, 1'b0);
        chk(rdrf == (k >= te), "R7 ready vs trigger on fill", rdrf, (k >= te));
      end
      for (int k = 1; k <= DEPTH; k++) begin
        read_chk(8'(k * 37 + t), "R10 arrival order");
        chk(rdrf == ((DEPTH - k) >= te), "R7 ready vs trigger on drain", rdrf,
            ((DEPTH - k) >= te));
      end
      chk(err_ovr == 1'b0, "R8 no overrun at depth", err_ovr, 0);
    end

    // R8: overrun in FIFO mode
    cfg_trig = CW'(1);
    for (int k = 0; k <= DEPTH; k++) send_frame(8'(8'h80 + k), 1'b0, 1'b1, 1'b0);
    chk(err_ovr == 1'b1, "R8 overrun fifo", err_ovr, 1);
    for (int k = 0; k < DEPTH; k++) read_chk(8'(8'h80 + k), "R8 held words intact");
    chk(rdrf == 1'b0, "R8 extra word dropped", rdrf, 0);
    clear_errs();
    chk(err_ovr == 1'b0, "R9 overrun cleared", err_ovr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule